// File: doc/BRIEF.md
# Dual-Channel Selectable Serial Bit Clock

This block derives two independent square-wave bit clocks from one 5.0688 MHz reference. Each output runs at sixteen times a selected baud rate, so it can drive a serial receiver and transmitter that oversample each bit sixteen times. Both directions of one serial link share the same output, so a channel always has one rate for sending and receiving.

Software picks a rate by putting a 4-bit code on the data input and pulsing the strobe of the channel it wants to change. The strobe captures the code into that channel alone. The sixteen codes select a fixed, non-uniform set of standard rates, listed below.

Each channel has a divide counter. Its period, counted in reference cycles, is the reference frequency divided by sixteen times the baud rate, rounded to the nearest integer. A new code restarts the counter, so the new rate takes effect at once and does not wait for the old period to finish.

Top module: `dual_baud_clk`

## Requirements
- R1: While `rst` is high, both outputs are held high, channel A loads code 7 (period 264 cycles) and channel B loads code 5 (period 1056 cycles). After `rst` falls, both channels run at those rates.
- R2: A cycle with `stb_a` high captures `rate_data[3:0]` as channel A's code. Channel B's code and output sequence are not affected.
- R3: A cycle with `stb_b` high captures `rate_data[3:0]` as channel B's code. Channel A's code and output sequence are not affected.
- R4: The output period in reference cycles for codes 0 to 15 is 6336, 4224, 2880, 2355, 2112, 1056, 528, 264, 176, 158, 132, 88, 66, 44, 33 and 17. These correspond to 50, 75, 110, 134.5, 150, 300, 600, 1200, 1800, 2000, 2400, 3600, 4800, 7200, 9600 and 19200 baud.
- R5: Within each period of P cycles, the output is high for the first P - floor(P/2) cycles and low for the remaining floor(P/2) cycles.
- R6: After a strobe edge, the channel's output is high and a fresh period at the new code starts in that cycle.
- R7: While no strobe is given, a channel keeps its code and its output repeats its period without a gap.
- R8: If both strobes are high in the same cycle, both channels capture the same code and restart together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 5.0688 MHz reference clock |
| rst | input | 1 | Synchronous active-high reset |
| rate_data | input | 4 | Rate code, captured on a strobe |
| stb_a | input | 1 | Load strobe for channel A |
| stb_b | input | 1 | Load strobe for channel B |
| bclk_a | output | 1 | Channel A clock at 16x its baud rate |
| bclk_b | output | 1 | Channel B clock at 16x its baud rate |

## Verification
- **Code capture:** a strobe at a rising edge loads the code at that edge.
- **Restart timing:** the registered output shows the restarted, high first phase one cycle after the strobe is driven. The bench drives inputs and samples outputs at the falling edge, so the first sample after a strobe already shows that high phase.
- **Reference model:** a behavioural model updates on the same rising edge and is compared with both outputs at every falling edge.
- **Period and duty:** separate checks count high and low runs at the falling edges. They confirm the period and duty for every code, and that a channel is left alone when the other channel's strobe fires.

// File: rtl/dual_baud_pkg.sv
package dual_baud_pkg;

    localparam int unsigned REF_HZ     = 5068800;
    localparam int unsigned OVERSAMPLE = 16;
    localparam int unsigned MIN_BAUD   = 50;
    localparam int          CODE_W     = 4;
    localparam int          NUM_CH     = 2;
    localparam int          CNT_W      = $clog2(REF_HZ / (OVERSAMPLE * MIN_BAUD) + 1);

    typedef logic [CODE_W-1:0] rate_code_t;
    typedef logic [CNT_W-1:0]  div_cnt_t;

    typedef struct packed {
        div_cnt_t period;
        div_cnt_t high_len;
    } div_cfg_t;

    // Baud rate in tenths, so the fractional 134.5 rate stays exact.
    function automatic int unsigned baud_x10(rate_code_t c);
        case (c)
            4'd0:    return 500;
            4'd1:    return 750;
            4'd2:    return 1100;
            4'd3:    return 1345;
            4'd4:    return 1500;
            4'd5:    return 3000;
            4'd6:    return 6000;
            4'd7:    return 12000;
            4'd8:    return 18000;
            4'd9:    return 20000;
            4'd10:   return 24000;
            4'd11:   return 36000;
            4'd12:   return 48000;
            4'd13:   return 72000;
            4'd14:   return 96000;
            default: return 192000;
        endcase
    endfunction

    // Period = REF / (16 * baud), rounded to nearest; high phase takes the odd cycle.
    function automatic div_cfg_t lookup_cfg(rate_code_t c);
        int unsigned twice;
        int unsigned p;
        div_cfg_t    cfg;
        twice        = (REF_HZ * 20) / (OVERSAMPLE * baud_x10(c));
        p            = (twice + 1) / 2;
        cfg.period   = div_cnt_t'(p);
        cfg.high_len = div_cnt_t'(p - p / 2);
        return cfg;
    endfunction

endpackage

// File: rtl/baud_code_reg.sv
module baud_code_reg
    import dual_baud_pkg::*;
#(
    parameter rate_code_t RESET_CODE = 4'd7
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  rate_code_t din,
    output rate_code_t code_q,
    output rate_code_t code_d
);

    always_comb begin
        code_d = load ? din : code_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            code_q <= RESET_CODE;
        end else begin
            code_q <= code_d;
        end
    end

endmodule

// File: rtl/baud_divider.sv
module baud_divider
    import dual_baud_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       restart,
    input  rate_code_t code_cur,
    input  rate_code_t code_nxt,
    output div_cnt_t   cnt_q,
    output logic       bclk
);

    div_cfg_t cfg_cur;
    div_cfg_t cfg_nxt;
    div_cnt_t cnt_d;
    logic     at_end;

    always_comb begin
        cfg_cur = lookup_cfg(code_cur);
        cfg_nxt = lookup_cfg(code_nxt);
        at_end  = (cnt_q == cfg_cur.period - 1'b1);
        if (restart || at_end) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            bclk  <= 1'b1;
        end else begin
            cnt_q <= cnt_d;
            bclk  <= (cnt_d < cfg_nxt.high_len);
        end
    end

endmodule

// File: rtl/dual_baud_clk.sv
module dual_baud_clk
    import dual_baud_pkg::*;
#(
    parameter rate_code_t RESET_CODE_A = 4'd7,
    parameter rate_code_t RESET_CODE_B = 4'd5
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [3:0] rate_data,
    input  logic       stb_a,
    input  logic       stb_b,
    output logic       bclk_a,
    output logic       bclk_b
);

    logic [NUM_CH-1:0] stb_v;
    logic [NUM_CH-1:0] bclk_v;
    rate_code_t        code_q [NUM_CH];
    rate_code_t        code_d [NUM_CH];
    div_cnt_t          cnt_q  [NUM_CH];

    assign stb_v  = {stb_b, stb_a};
    assign bclk_a = bclk_v[0];
    assign bclk_b = bclk_v[1];

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
        baud_code_reg #(
            .RESET_CODE((ch == 0) ? RESET_CODE_A : RESET_CODE_B)
        ) u_code (
            .clk    (clk),
            .rst    (rst),
            .load   (stb_v[ch]),
            .din    (rate_data),
            .code_q (code_q[ch]),
            .code_d (code_d[ch])
        );

        baud_divider u_div (
            .clk      (clk),
            .rst      (rst),
            .restart  (stb_v[ch]),
            .code_cur (code_q[ch]),
            .code_nxt (code_d[ch]),
            .cnt_q    (cnt_q[ch]),
            .bclk     (bclk_v[ch])
        );
    end

endmodule

// File: rtl/dual_baud_chk.sv
module dual_baud_chk
    import dual_baud_pkg::*;
#(
    parameter rate_code_t RST_A = 4'd7,
    parameter rate_code_t RST_B = 4'd5
) (
    input logic              clk,
    input logic              rst,
    input logic [3:0]        rate_data,
    input logic [NUM_CH-1:0] stb,
    input rate_code_t        code_q [NUM_CH],
    input div_cnt_t          cnt_q  [NUM_CH],
    input logic [NUM_CH-1:0] bclk
);

    // R1: reset loads the per-channel default codes and a high output
    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (code_q[0] == RST_A && code_q[1] == RST_B && bclk == 2'b11));

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chk
        // R2, R3: a strobe captures the data nibble for its own channel
        assert_code_capture_R2: assert property (@(posedge clk) disable iff (rst)
            stb[ch] |=> code_q[ch] == $past(rate_data));

        // R7: without a strobe the code is held
        assert_code_hold_R7: assert property (@(posedge clk) disable iff (rst)
            !stb[ch] |=> $stable(code_q[ch]));

        // R6: a strobe restarts the period with the high phase
        assert_restart_R6: assert property (@(posedge clk) disable iff (rst)
            stb[ch] |=> (cnt_q[ch] == '0 && bclk[ch]));

        // R4: counter stays inside the selected period
        assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (rst)
            cnt_q[ch] < lookup_cfg(code_q[ch]).period);

        // R5: output falls only at the end of the high phase
        assert_duty_edge_R5: assert property (@(posedge clk) disable iff (rst)
            $fell(bclk[ch]) |-> cnt_q[ch] == lookup_cfg(code_q[ch]).high_len);
    end

endmodule

bind dual_baud_clk dual_baud_chk #(
    .RST_A (RESET_CODE_A),
    .RST_B (RESET_CODE_B)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .rate_data (rate_data),
    .stb       (stb_v),
    .code_q    (code_q),
    .cnt_q     (cnt_q),
    .bclk      (bclk_v)
);

// File: tb/dual_baud_clk_bench.sv
module dual_baud_clk_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] rate_data = 4'd0;
    logic       stb_a = 1'b0;
    logic       stb_b = 1'b0;
    logic       bclk_a;
    logic       bclk_b;

    int checks = 0;
    int errors = 0;

    int per_tab [16] = '{6336, 4224, 2880, 2355, 2112, 1056, 528, 264,
                         176, 158, 132, 88, 66, 44, 33, 17};

    // behavioural model state
    int mcode [2];
    int mcnt  [2];
    bit model_ok = 1'b0;

    always #2 clk = ~clk;

    dual_baud_clk u_dual_baud_clk (
        .clk       (clk),
        .rst       (rst),
        .rate_data (rate_data),
        .stb_a     (stb_a),
        .stb_b     (stb_b),
        .bclk_a    (bclk_a),
        .bclk_b    (bclk_b)
    );

    function automatic int hi_len(int code);
        return per_tab[code] - per_tab[code] / 2;
    endfunction

    function automatic logic get_clk(int ch);
        return (ch == 0) ? bclk_a : bclk_b;
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (rst) begin
            mcode[0] = 7;
            mcode[1] = 5;
            mcnt[0]  = 0;
            mcnt[1]  = 0;
            model_ok = 1'b1;
        end else if (model_ok) begin
            for (int ch = 0; ch < 2; ch++) begin
                if ((ch == 0) ? stb_a : stb_b) begin
                    mcode[ch] = int'(rate_data);
                    mcnt[ch]  = 0;
                end else if (mcnt[ch] + 1 == per_tab[mcode[ch]]) begin
                    mcnt[ch] = 0;
                end else begin
                    mcnt[ch] = mcnt[ch] + 1;
                end
            end
        end
    end

    // R7: cycle-by-cycle comparison with the model
    always @(negedge clk) begin
        if (model_ok) begin
            for (int ch = 0; ch < 2; ch++) begin
                int exp_v;
                exp_v = (mcnt[ch] < hi_len(mcode[ch])) ? 1 : 0;
                check(int'(get_clk(ch)) == exp_v, (ch == 0) ? "R7 model chA" : "R7 model chB",
                      int'(get_clk(ch)), exp_v);
            end
        end
    end

    task automatic strobe(bit a, bit b, int code);
        @(negedge clk);
        rate_data = code[3:0];
        stb_a = a;
        stb_b = b;
        @(negedge clk);
        stb_a = 1'b0;
        stb_b = 1'b0;
    endtask

    // R6/R5: output high right after strobe, high run matches new code
    task automatic check_restart(int ch, int code);
        int n;
        check(get_clk(ch) == 1'b1, "R6 restart high", int'(get_clk(ch)), 1);
        n = 0;
        while (get_clk(ch) == 1'b1) begin
            n++;
            @(negedge clk);
        end
        check(n == hi_len(code), "R5/R6 first high run", n, hi_len(code));
    endtask

    task automatic measure(int ch, int code, string req);
        int hi;
        int lo;
        hi = 0;
        lo = 0;
        while (get_clk(ch) == 1'b1) @(negedge clk);
        while (get_clk(ch) == 1'b0) @(negedge clk);
        while (get_clk(ch) == 1'b1) begin
            hi++;
            @(negedge clk);
        end
        while (get_clk(ch) == 1'b0) begin
            lo++;
            @(negedge clk);
        end
        check(hi + lo == per_tab[code], req, hi + lo, per_tab[code]);
        check(hi == hi_len(code), "R5 high phase", hi, hi_len(code));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R7 watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs high while reset is applied
        check(bclk_a == 1'b1, "R1 reset bclk_a", int'(bclk_a), 1);
        check(bclk_b == 1'b1, "R1 reset bclk_b", int'(bclk_b), 1);
        rst = 1'b0;
        measure(0, 7, "R1 chA default period");
        measure(1, 5, "R1 chB default period");

        // R2: loading A leaves B at its default
        strobe(1'b1, 1'b0, 11);
        check_restart(0, 11);
        measure(1, 5, "R2 chB untouched");
        measure(0, 11, "R2 chA new period");

        // R4: every code on channel A
        for (int c = 0; c < 16; c++) begin
            strobe(1'b1, 1'b0, c);
            check_restart(0, c);
            measure(0, c, "R4 period table");
        end

        // R3: loading B leaves A at code 15
        strobe(1'b0, 1'b1, 9);
        check_restart(1, 9);
        measure(0, 15, "R3 chA untouched");
        measure(1, 9, "R3 chB new period");

        // R6: mid-period reload on A
        strobe(1'b1, 1'b0, 12);
        repeat (20) @(negedge clk);
        strobe(1'b1, 1'b0, 10);
        check_restart(0, 10);

        // R8: both strobes at once
        strobe(1'b1, 1'b1, 14);
        check(bclk_a == 1'b1 && bclk_b == 1'b1, "R8 both restart", int'({bclk_a, bclk_b}), 3);
        measure(0, 14, "R8 chA period");
        measure(1, 14, "R8 chB period");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule